// File: doc/BRIEF.md
# Three-Cell Series Pack Protection Controller

This block supervises a pack of three cells in series and decides, every clock, whether the charge FET and the discharge FET may be on. It works on digital flags only. Each cell has four comparator flags, already resolved: above the over-charge level, at or below the over-charge release level, below the over-discharge level, and at or above the over-discharge release level. Pack-level flags report that a load is detected, that a charger is detected, and that a separate over-current detector has tripped. A control pin can inhibit both FETs, and its active level is chosen at build time.

Over-charge and over-discharge are qualified by delay counters. These advance on a clock-enable tick and restart whenever their condition drops out. Over-charge and over-discharge are tracked as independent states, so both can hold at once. While over-charge holds, a bleed output is raised for each cell that went over the limit. Entering over-discharge also raises a power-down flag, which only a charger clears. A build option forces the charge FET on while a charger is present, so that a fully depleted pack can still be charged.

Top module: `cellpack_guard`

## Requirements
- R1: After reset, with the control pin inactive and all flags quiet, chg_en=1, dsg_en=1, pwr_down=0 and bleed=0.
- R2: In the normal state (no over-charge, no over-discharge, no over-current, no inhibit), both FET enables are 1.
- R3: When any bit of cell_hi is 1 for OVC_TICKS consecutive ticks, chg_en goes to 0 and dsg_en stays 1. If cell_hi drops to all zero before then, the count restarts from zero.
- R4: While over-charge holds, bleed[i]=1 for each cell i that had cell_hi[i]=1 (at entry or later). bleed[i] goes to 0 once cell_hi_rel[i]=1. Other bits stay 0, and over-charge ends when no bleed bit remains.
- R5: load_seen=1 ends over-charge on the next edge, with bleed cleared, even if the cells are still above their release level.
- R6: When any bit of cell_lo is 1 for OVD_TICKS consecutive ticks, dsg_en goes to 0 and pwr_down goes to 1. A dropout restarts the count.
- R7: pwr_down goes to 0 only on an edge with charger_seen=1. Over-discharge ends on a later edge, only when every bit of cell_lo_rel is 1 and pwr_down is 0. dsg_en then returns to 1. While pwr_down=1, chg_en=0.
- R8: Over-charge and over-discharge can hold together, with both enables at 0. With both held, charger_seen=0 ends over-charge on the next edge and keeps over-discharge.
- R9: The control pin inhibits when it equals 1 with CTL_REVERSE=0, or when it equals 0 with CTL_REVERSE=1. Inhibit forces both enables to 0 in the same cycle. Releasing it restores the values the pack state dictates.
- R10: ocp_trip=1 latches over-current from the next edge, with both enables at 0. The latch clears on the first edge where load_seen=0 and ocp_trip=0.
- R11: With ZERO_V_CHG=1, chg_en=1 whenever charger_seen=1, the pin does not inhibit and over-charge does not hold. This overrides over-current and power-down. With ZERO_V_CHG=0, charger_seen has no such effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Delay-counter clock enable |
| cell_hi | input | NCELL | Cell above over-charge level |
| cell_hi_rel | input | NCELL | Cell at or below over-charge release level |
| cell_lo | input | NCELL | Cell below over-discharge level |
| cell_lo_rel | input | NCELL | Cell at or above over-discharge release level |
| load_seen | input | 1 | Load detected on the pack terminals |
| charger_seen | input | 1 | Charger detected |
| ocp_trip | input | 1 | Over-current trip from external detector |
| ctl_pin | input | 1 | Control inhibit pin |
| chg_en | output | 1 | Charge FET enable |
| dsg_en | output | 1 | Discharge FET enable |
| pwr_down | output | 1 | Power-down flag |
| bleed | output | NCELL | Per-cell conditioning output |

## Verification
Some properties are checked on every cycle. An inhibit forces both enables off. Over-charge keeps the charge FET off, and over-discharge keeps the discharge FET off. Power-down implies over-discharge and ends only after a charger was seen. Over-discharge ends only with all cells released, and over-charge starts only when its delay expires. Other behaviour needs the bench's scenarios: the exact tick on which a delay expires and the restart after a dropout, the per-cell bleed pattern, the two routes out of over-charge, the combined state and the charger removal, and the zero-volt override against a build without it.

// File: rtl/cpg_pkg.sv
package cpg_pkg;

  typedef struct packed {
    logic chg;
    logic dsg;
  } fet_pair_t;

  // Active level of the control pin chosen by build option.
  function automatic logic ctl_inhibit(input logic pin, input bit reverse);
    return reverse ? ~pin : pin;
  endfunction

  // FET decision from the pack state.
  function automatic fet_pair_t fet_drive(input logic inhibit, input logic ocp,
                                          input logic ovc, input logic ovd,
                                          input logic pd, input logic zv_force);
    fet_pair_t f;
    f.chg = ~inhibit & (zv_force | (~ocp & ~ovc & ~pd));
    f.dsg = ~inhibit & ~ocp & ~ovd;
    return f;
  endfunction

endpackage

// File: rtl/cpg_delay_timer.sv
module cpg_delay_timer #(
  parameter int DLY = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic arm,
  output logic fire
);
  localparam int W = $clog2(DLY + 1);
  localparam logic [W-1:0] LAST = W'(DLY - 1);

  logic [W-1:0] cnt;

  assign fire = arm & tick & (cnt == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cnt <= '0;
    else if (!arm || fire) cnt <= '0;
    else if (tick)         cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/cpg_ovc_tracker.sv
module cpg_ovc_tracker #(
  parameter int NCELL = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fire,
  input  logic [NCELL-1:0] hi,
  input  logic [NCELL-1:0] hi_rel,
  input  logic             clear_ext,
  output logic [NCELL-1:0] flags
);
  logic [NCELL-1:0] nxt;

  always_comb nxt = (flags & ~hi_rel) | hi;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      flags <= '0;
    else if (fire)   flags <= hi;
    else if (|flags) flags <= clear_ext ? '0 : nxt;
  end
endmodule

// File: rtl/cpg_ovd_tracker.sv
module cpg_ovd_tracker (
  input  logic clk,
  input  logic rst_n,
  input  logic fire,
  input  logic charger,
  input  logic all_rel,
  output logic ovd_active,
  output logic pd
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ovd_active <= 1'b0;
      pd         <= 1'b0;
    end else if (fire) begin
      ovd_active <= 1'b1;
      pd         <= 1'b1;
    end else if (pd) begin
      if (charger) pd <= 1'b0;
    end else if (ovd_active && all_rel) begin
      ovd_active <= 1'b0;
    end
  end
endmodule

// File: rtl/cellpack_guard.sv
module cellpack_guard #(
  parameter int NCELL       = 3,
  parameter int OVC_TICKS   = 8,
  parameter int OVD_TICKS   = 4,
  parameter bit CTL_REVERSE = 1'b0,
  parameter bit ZERO_V_CHG  = 1'b0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic [NCELL-1:0] cell_hi,
  input  logic [NCELL-1:0] cell_hi_rel,
  input  logic [NCELL-1:0] cell_lo,
  input  logic [NCELL-1:0] cell_lo_rel,
  input  logic             load_seen,
  input  logic             charger_seen,
  input  logic             ocp_trip,
  input  logic             ctl_pin,
  output logic             chg_en,
  output logic             dsg_en,
  output logic             pwr_down,
  output logic [NCELL-1:0] bleed
);
  import cpg_pkg::*;

  logic [NCELL-1:0] ovc_flags;
  logic ovc_active, ovd_active, ovc_fire, ovd_fire;
  logic ovc_arm, ovd_arm, ovc_clear, ocp_latched, inhibit, zv_force;
  fet_pair_t fets;

  assign ovc_active = |ovc_flags;
  assign ovc_arm    = (|cell_hi) & ~ovc_active;
  assign ovd_arm    = (|cell_lo) & ~ovd_active;
  assign ovc_clear  = load_seen | (ovd_active & ~charger_seen);
  assign inhibit    = ctl_inhibit(ctl_pin, CTL_REVERSE);
  assign zv_force   = ZERO_V_CHG & charger_seen & ~ovc_active;

  cpg_delay_timer #(.DLY(OVC_TICKS)) u_ovc_tmr (
    .clk(clk), .rst_n(rst_n), .tick(tick), .arm(ovc_arm), .fire(ovc_fire));

  cpg_delay_timer #(.DLY(OVD_TICKS)) u_ovd_tmr (
    .clk(clk), .rst_n(rst_n), .tick(tick), .arm(ovd_arm), .fire(ovd_fire));

  cpg_ovc_tracker #(.NCELL(NCELL)) u_ovc (
    .clk(clk), .rst_n(rst_n), .fire(ovc_fire), .hi(cell_hi),
    .hi_rel(cell_hi_rel), .clear_ext(ovc_clear), .flags(ovc_flags));

  cpg_ovd_tracker u_ovd (
    .clk(clk), .rst_n(rst_n), .fire(ovd_fire), .charger(charger_seen),
    .all_rel(&cell_lo_rel), .ovd_active(ovd_active), .pd(pwr_down));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          ocp_latched <= 1'b0;
    else if (ocp_trip)   ocp_latched <= 1'b1;
    else if (!load_seen) ocp_latched <= 1'b0;
  end

  assign fets   = fet_drive(inhibit, ocp_latched, ovc_active, ovd_active, pwr_down, zv_force);
  assign chg_en = fets.chg;
  assign dsg_en = fets.dsg;
  assign bleed  = ovc_flags;
endmodule

// File: rtl/cpg_checker.sv
module cpg_checker #(
  parameter int NCELL = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic [NCELL-1:0] cell_lo_rel,
  input logic             charger_seen,
  input logic             ocp_trip,
  input logic             chg_en,
  input logic             dsg_en,
  input logic             pwr_down,
  input logic             ovc_active,
  input logic             ovd_active,
  input logic             ovc_fire,
  input logic             inhibit
);
  // R9
  inhibit_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    inhibit |-> (!chg_en && !dsg_en));

  // R3
  ovc_chg_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ovc_active |-> !chg_en);

  // R3
  ovc_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovc_active) |-> $past(ovc_fire));

  // R6
  ovd_dsg_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ovd_active |-> !dsg_en);

  // R6
  pd_in_ovd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_down |-> ovd_active);

  // R7
  pd_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pwr_down) |-> $past(charger_seen));

  // R7
  ovd_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ovd_active) |-> ($past(&cell_lo_rel) && !$past(pwr_down)));

  // R10
  ocp_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ocp_trip |=> !dsg_en);
endmodule

bind cellpack_guard cpg_checker #(.NCELL(NCELL)) u_chk (
  .clk(clk), .rst_n(rst_n), .cell_lo_rel(cell_lo_rel),
  .charger_seen(charger_seen), .ocp_trip(ocp_trip), .chg_en(chg_en),
  .dsg_en(dsg_en), .pwr_down(pwr_down), .ovc_active(ovc_active),
  .ovd_active(ovd_active), .ovc_fire(ovc_fire), .inhibit(inhibit));

// File: tb/cellpack_guard_tb.sv
module cellpack_guard_tb;
  localparam int N   = 3;
  localparam int OVC = 6;
  localparam int OVD = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 1'b1;
  logic [N-1:0] cell_hi = '0, cell_hi_rel = '1, cell_lo = '0, cell_lo_rel = '1;
  logic load_seen = 1'b0, charger_seen = 1'b0, ocp_trip = 1'b0;
  logic ctl_pin = 1'b0, ctl_alt = 1'b1;
  logic chg_en, dsg_en, pwr_down;
  logic [N-1:0] bleed;
  logic chg_a, dsg_a, pd_a;
  logic [N-1:0] bleed_a;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  cellpack_guard #(.NCELL(N), .OVC_TICKS(OVC), .OVD_TICKS(OVD),
                   .CTL_REVERSE(1'b0), .ZERO_V_CHG(1'b0)) u_dut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .cell_hi(cell_hi),
    .cell_hi_rel(cell_hi_rel), .cell_lo(cell_lo), .cell_lo_rel(cell_lo_rel),
    .load_seen(load_seen), .charger_seen(charger_seen), .ocp_trip(ocp_trip),
    .ctl_pin(ctl_pin), .chg_en(chg_en), .dsg_en(dsg_en),
    .pwr_down(pwr_down), .bleed(bleed));

  cellpack_guard #(.NCELL(N), .OVC_TICKS(OVC), .OVD_TICKS(OVD),
                   .CTL_REVERSE(1'b1), .ZERO_V_CHG(1'b1)) u_dut_alt (
    .clk(clk), .rst_n(rst_n), .tick(tick), .cell_hi(cell_hi),
    .cell_hi_rel(cell_hi_rel), .cell_lo(cell_lo), .cell_lo_rel(cell_lo_rel),
    .load_seen(load_seen), .charger_seen(charger_seen), .ocp_trip(ocp_trip),
    .ctl_pin(ctl_alt), .chg_en(chg_a), .dsg_en(dsg_a),
    .pwr_down(pd_a), .bleed(bleed_a));

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic t_reset;
    // R1, R2
    chk("R1", "chg_en", 32'(chg_en), 1);
    chk("R1", "dsg_en", 32'(dsg_en), 1);
    chk("R1", "pwr_down", 32'(pwr_down), 0);
    chk("R1", "bleed", 32'(bleed), 0);
    step(3);
    chk("R2", "chg_en idle", 32'(chg_en), 1);
    chk("R2", "dsg_en idle", 32'(dsg_en), 1);
  endtask

  task automatic t_overcharge;
    cell_hi = 3'b010; cell_hi_rel = 3'b101;
    step(OVC - 1);
    cell_hi = 3'b000;
    step(1);
    cell_hi = 3'b010;
    step(OVC - 1);
    chk("R3", "chg_en before expiry after restart", 32'(chg_en), 1);
    step(1);
    chk("R3", "chg_en at expiry", 32'(chg_en), 0);
    chk("R3", "dsg_en stays on", 32'(dsg_en), 1);
    chk("R4", "bleed single cell", 32'(bleed), 32'b010);
    cell_hi = 3'b011; cell_hi_rel = 3'b100;
    step(1);
    chk("R4", "bleed second cell joins", 32'(bleed), 32'b011);
    cell_hi = 3'b001; cell_hi_rel = 3'b110;
    step(1);
    chk("R4", "bleed cell1 released", 32'(bleed), 32'b001);
    chk("R4", "chg_en still off", 32'(chg_en), 0);
    cell_hi = 3'b000; cell_hi_rel = 3'b111;
    step(1);
    chk("R4", "bleed all released", 32'(bleed), 0);
    chk("R4", "chg_en back on", 32'(chg_en), 1);
  endtask

  task automatic t_load_release;
    cell_hi = 3'b100; cell_hi_rel = 3'b011;
    step(OVC);
    chk("R5", "chg_en off before load", 32'(chg_en), 0);
    load_seen = 1'b1;
    step(1);
    chk("R5", "chg_en on after load", 32'(chg_en), 1);
    chk("R5", "bleed cleared by load", 32'(bleed), 0);
    cell_hi = 3'b000; cell_hi_rel = 3'b111; load_seen = 1'b0;
    step(1);
  endtask

  task automatic t_overdischarge;
    cell_lo = 3'b001; cell_lo_rel = 3'b110;
    step(OVD - 1);
    cell_lo = 3'b000;
    step(1);
    cell_lo = 3'b001;
    step(OVD - 1);
    chk("R6", "dsg_en before expiry after restart", 32'(dsg_en), 1);
    step(1);
    chk("R6", "dsg_en at expiry", 32'(dsg_en), 0);
    chk("R6", "pwr_down at expiry", 32'(pwr_down), 1);
    chk("R7", "chg_en off in power-down", 32'(chg_en), 0);
    cell_lo = 3'b000; cell_lo_rel = 3'b111;
    step(2);
    chk("R7", "power-down held without charger", 32'(pwr_down), 1);
    chk("R7", "dsg_en held without charger", 32'(dsg_en), 0);
    cell_lo_rel = 3'b110;
    charger_seen = 1'b1;
    step(2);
    chk("R7", "power-down ends with charger", 32'(pwr_down), 0);
    chk("R7", "dsg_en off until all released", 32'(dsg_en), 0);
    cell_lo_rel = 3'b111;
    step(1);
    chk("R7", "dsg_en on after all released", 32'(dsg_en), 1);
    charger_seen = 1'b0;
    step(1);
  endtask

  task automatic t_both;
    cell_lo = 3'b001; cell_lo_rel = 3'b110;
    step(OVD);
    charger_seen = 1'b1; cell_lo = 3'b000;
    step(1);
    cell_hi = 3'b100; cell_hi_rel = 3'b011;
    step(OVC);
    chk("R8", "chg_en off with both", 32'(chg_en), 0);
    chk("R8", "dsg_en off with both", 32'(dsg_en), 0);
    chk("R8", "bleed with both", 32'(bleed), 32'b100);
    charger_seen = 1'b0;
    step(1);
    chk("R8", "over-charge cleared on charger removal", 32'(bleed), 0);
    chk("R8", "dsg_en still off", 32'(dsg_en), 0);
    cell_hi = 3'b000; cell_hi_rel = 3'b111; cell_lo_rel = 3'b111;
    step(1);
    chk("R8", "dsg_en on after over-discharge release", 32'(dsg_en), 1);
  endtask

  task automatic t_control;
    ctl_pin = 1'b1; #1;
    chk("R9", "normal polarity high inhibits chg", 32'(chg_en), 0);
    chk("R9", "normal polarity high inhibits dsg", 32'(dsg_en), 0);
    ctl_alt = 1'b0; #1;
    chk("R9", "reverse polarity low inhibits", 32'({chg_a, dsg_a}), 0);
    ctl_alt = 1'b1; #1;
    chk("R9", "reverse polarity high enables", 32'({chg_a, dsg_a}), 32'b11);
    ctl_pin = 1'b0;
    step(1);
    cell_hi = 3'b001; cell_hi_rel = 3'b110;
    step(OVC);
    ctl_pin = 1'b1; #1;
    chk("R9", "inhibit during over-charge", 32'({chg_en, dsg_en}), 0);
    ctl_pin = 1'b0; #1;
    chk("R9", "release returns to state", 32'({chg_en, dsg_en}), 32'b01);
    cell_hi = 3'b000; cell_hi_rel = 3'b111;
    step(1);
    chk("R9", "back to normal", 32'({chg_en, dsg_en}), 32'b11);
  endtask

  task automatic t_overcurrent;
    ocp_trip = 1'b1; load_seen = 1'b1;
    step(1);
    ocp_trip = 1'b0;
    step(2);
    chk("R10", "enables off while load held", 32'({chg_en, dsg_en}), 0);
    charger_seen = 1'b1; #1;
    chk("R11", "no override without zero-volt build", 32'(chg_en), 0);
    chk("R11", "zero-volt build forces charge on", 32'(chg_a), 1);
    chk("R11", "zero-volt build keeps discharge off", 32'(dsg_a), 0);
    charger_seen = 1'b0;
    load_seen = 1'b0;
    step(1);
    chk("R10", "enables restored after load release", 32'({chg_en, dsg_en}), 32'b11);
  endtask

  initial begin
    #(4 * 100000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    step(3);
    rst_n = 1'b1;
    #1;
    t_reset();
    t_overcharge();
    t_load_release();
    t_overdischarge();
    t_both();
    t_control();
    t_overcurrent();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule